// File: doc/BRIEF.md
# Synchronous master serial receiver

This block receives serial words as the clock master of a two-wire synchronous link. It generates the shift clock from a programmable divider and drives it out. It samples the data line on each falling edge of that clock and collects the bits, least significant first, into a shift register. A word is 8 bits, or 9 when the ninth-bit option is on. Each finished word goes into a two-entry receive FIFO, and software reads that FIFO through a register-style port: the oldest entry's data byte, its ninth bit, and a status set.

Reception starts from a control write. The single-word enable fetches one word and then clears itself. The continuous enable keeps fetching words until software clears it. If both are set, the continuous enable wins.

A word can finish while both FIFO entries are full. In that case the word is dropped and a sticky overrun flag is raised. The overrun freezes the shift clock, and only a control write that leaves the continuous enable at 0 clears it. A data-available flag, gated by an interrupt enable, gives the interrupt output.

Top module: `sync_rx_master`

## Requirements
- R1: Each period of `sclk_o` lasts (`baud_div`+1)*4 cycles of `clk`, measured from rising edge to rising edge. `sclk_o` stays low while no enable is active or while an overrun is pending.
- R2: Data on `sdata_i` is sampled on each falling edge of `sclk_o`, and the first bit is the least significant. With `ctl_nine`=0 a word is 8 bits and lands in `rd_data[7:0]`. With `ctl_nine`=1 a word is 9 bits and its last bit appears on `rd_bit9`.
- R3: With only the single-word enable set, exactly one word is received. `st_single` then reads 0 and `sclk_o` stops.
- R4: With the continuous enable set, words are received back to back until a control write clears it. Clearing it stops the clock.
- R5: With both enables set, reception continues past the first word, and `st_cont` stays 1.
- R6: Each FIFO entry keeps its own ninth bit. `rd_data` and `rd_bit9` show the oldest entry. A pulse on `rd_pop` advances both together to the next entry.
- R7: The FIFO holds two words. A `rd_pop` while the FIFO is empty has no effect on later words.
- R8: If a word completes while the FIFO is full, `st_ovr` is set and that word is discarded. `sclk_o` then stops, and no word enters the FIFO while `st_ovr` is 1.
- R9: `st_ovr` clears only on a control write with `ctl_cont`=0. A write with `ctl_cont`=1 leaves it set.
- R10: `rx_flag` is 1 exactly while the FIFO holds a word, and it goes high in the cycle after a word enters. `irq` equals `rx_flag` AND the stored interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_single | input | 1 | Single-word enable value to write |
| ctl_cont | input | 1 | Continuous enable value to write (0 clears overrun) |
| ctl_nine | input | 1 | Nine-bit word length value to write |
| ctl_ie | input | 1 | Interrupt enable value to write |
| baud_div | input | DIV_W | Shift clock divider |
| rd_pop | input | 1 | Removes the oldest FIFO entry |
| sdata_i | input | 1 | Serial data line |
| sclk_o | output | 1 | Generated shift clock |
| rd_data | output | 8 | Data byte of the oldest entry |
| rd_bit9 | output | 1 | Ninth bit of the oldest entry |
| st_single | output | 1 | Single-word enable state |
| st_cont | output | 1 | Continuous enable state |
| st_ovr | output | 1 | Sticky overrun flag |
| rx_flag | output | 1 | Data-available flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the overrun. It needs two unread words in the FIFO and a third word to finish shifting while they are still there. It must also be shown afterwards that the third word never reached the FIFO. The bench gets there by stopping its reader and running continuous mode until `st_ovr` rises. It then checks that the clock is frozen and that a control write keeping the continuous enable set does not clear the flag. Finally it clears the overrun and drains the FIFO, which must yield exactly the first two words and then an empty flag. A modelled slave changes the data line only on rising clock edges, so a receiver that samples on the wrong edge returns shifted words.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int RX_DATA_W = 8;
  localparam int RX_WORD_MAX = RX_DATA_W + 1;

  typedef struct packed {
    logic                 bit9;
    logic [RX_DATA_W-1:0] data;
  } rx_word_t;

  typedef struct packed {
    logic single;
    logic cont;
    logic nine;
    logic ie;
  } rx_ctl_t;
endpackage

// File: rtl/sync_rx_baud.sv
module sync_rx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall_tick
);
  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic             sclk_q, sclk_d;
  logic             expire;

  // half period is (div+1)*2 cycles, so its last count is 2*div+1
  assign half_m1 = {1'b0, div, 1'b1};
  assign expire  = run && (cnt_q == half_m1);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (expire) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk      = sclk_q;
  assign fall_tick = expire && sclk_q;

  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= half_m1 || !run);
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift
  import sync_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     tick,
  input  logic     sdi,
  input  logic     nine,
  output logic     done,
  output rx_word_t word
);
  localparam int BIT_W = $clog2(RX_WORD_MAX + 1);

  logic [RX_WORD_MAX-1:0] sh_q, sh_nx;
  logic [BIT_W-1:0]       bit_q, bit_d, last_idx;
  logic                   shift_en;

  assign last_idx = nine ? BIT_W'(RX_WORD_MAX - 1) : BIT_W'(RX_DATA_W - 1);
  assign shift_en = run && tick;
  assign sh_nx    = {sdi, sh_q[RX_WORD_MAX-1:1]};
  assign done     = shift_en && (bit_q == last_idx);

  always_comb begin
    bit_d = bit_q;
    if (!run)          bit_d = '0;
    else if (done)     bit_d = '0;
    else if (shift_en) bit_d = bit_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= '0;
    else        bit_q <= bit_d;
  end

  always_ff @(posedge clk) begin
    if (shift_en) sh_q <= sh_nx;
  end

  // word view of the register including the bit sampled this cycle
  always_comb begin
    if (nine) begin
      word.data = sh_nx[RX_DATA_W-1:0];
      word.bit9 = sh_nx[RX_WORD_MAX-1];
    end else begin
      word.data = sh_nx[RX_WORD_MAX-1:1];
      word.bit9 = 1'b0;
    end
  end

  p_bitcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BIT_W'(RX_WORD_MAX - 1));
  p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> bit_q == '0);
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo
  import sync_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  logic     pop,
  input  rx_word_t din,
  output rx_word_t dout,
  output logic     empty,
  output logic     full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_word_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr, rd;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign wr    = push && !full;
  assign rd    = pop && !empty;

  always_comb begin
    wp_d  = wr ? ptr_inc(wp_q) : wp_q;
    rp_d  = rd ? ptr_inc(rp_q) : rp_q;
    cnt_d = cnt_q + CNT_W'(wr) - CNT_W'(rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr && (wp_q == PTR_W'(g))) mem_q[g] <= din;
    end
  end

  assign dout = mem_q[rp_q];

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic                 ctl_single,
  input  logic                 ctl_cont,
  input  logic                 ctl_nine,
  input  logic                 ctl_ie,
  input  logic [DIV_W-1:0]     baud_div,
  input  logic                 rd_pop,
  input  logic                 sdata_i,
  output logic                 sclk_o,
  output logic [RX_DATA_W-1:0] rd_data,
  output logic                 rd_bit9,
  output logic                 st_single,
  output logic                 st_cont,
  output logic                 st_ovr,
  output logic                 rx_flag,
  output logic                 irq
);
  logic [1:0] rst_sync_q;
  logic       rst_i;
  rx_ctl_t    ctl_q, ctl_d;
  logic       ovr_q, ovr_d;
  logic       run, fall_tick, word_done, push, fifo_empty, fifo_full;
  rx_word_t   shift_word, head;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign run  = (ctl_q.single || ctl_q.cont) && !ovr_q;
  assign push = word_done && !fifo_full && !ovr_q;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d.single = ctl_single;
      ctl_d.cont   = ctl_cont;
      ctl_d.nine   = ctl_nine;
      ctl_d.ie     = ctl_ie;
    end else if (word_done) begin
      ctl_d.single = 1'b0;
    end
  end

  always_comb begin
    ovr_d = ovr_q;
    if (ctl_we && !ctl_cont)     ovr_d = 1'b0;
    else if (word_done && fifo_full) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctl_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      ovr_q <= ovr_d;
    end
  end

  sync_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk       (clk),
    .rst_n     (rst_i),
    .run       (run),
    .div       (baud_div),
    .sclk      (sclk_o),
    .fall_tick (fall_tick)
  );

  sync_rx_shift u_shift (
    .clk   (clk),
    .rst_n (rst_i),
    .run   (run),
    .tick  (fall_tick),
    .sdi   (sdata_i),
    .nine  (ctl_q.nine),
    .done  (word_done),
    .word  (shift_word)
  );

  sync_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_i),
    .push  (push),
    .pop   (rd_pop),
    .din   (shift_word),
    .dout  (head),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign rd_data   = head.data;
  assign rd_bit9   = head.bit9;
  assign st_single = ctl_q.single;
  assign st_cont   = ctl_q.cont;
  assign st_ovr    = ovr_q;
  assign rx_flag   = !fifo_empty;
  assign irq       = rx_flag && ctl_q.ie;

  p_ovr_halts_r8: assert property (@(posedge clk) disable iff (!rst_i)
    st_ovr |=> !sclk_o);
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_i)
    st_ovr && !(ctl_we && !ctl_cont) |=> st_ovr);
  p_flag_after_push_r10: assert property (@(posedge clk) disable iff (!rst_i)
    push |=> rx_flag);
  p_single_clears_r3: assert property (@(posedge clk) disable iff (!rst_i)
    word_done && !ctl_we |=> !st_single);
endmodule

// File: tb/sync_rx_master_tb.sv
module sync_rx_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic             clk, rst_n;
  logic             ctl_we, ctl_single, ctl_cont, ctl_nine, ctl_ie;
  logic [DIV_W-1:0] baud_div;
  logic             mon_pop, man_pop, rd_pop;
  logic             sdata_i;
  logic             sclk_o, rd_bit9, st_single, st_cont, st_ovr, rx_flag, irq;
  logic [7:0]       rd_data;

  int checks = 0;
  int errors = 0;
  bit auto_pop = 0, discard_ok = 0, rst_done = 0, nine_mode = 0;
  logic [8:0] send_q[$];
  logic [8:0] exp_q[$];
  logic [8:0] cur_word = '0;
  int slave_idx = 0;
  int rise_cnt = 0;
  time t_prev = 0, t_last = 0;

  assign rd_pop = mon_pop | man_pop;

  sync_rx_master #(.DIV_W(DIV_W), .FIFO_DEPTH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_single(ctl_single),
    .ctl_cont(ctl_cont), .ctl_nine(ctl_nine), .ctl_ie(ctl_ie),
    .baud_div(baud_div), .rd_pop(rd_pop), .sdata_i(sdata_i),
    .sclk_o(sclk_o), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .st_single(st_single), .st_cont(st_cont), .st_ovr(st_ovr),
    .rx_flag(rx_flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave: changes data only on rising shift clock edges, LSB first
  always @(posedge sclk_o) begin
    t_prev = t_last;
    t_last = $time;
    rise_cnt++;
    if (slave_idx == 0) cur_word = (send_q.size() != 0) ? send_q.pop_front() : 9'h000;
    sdata_i = cur_word[slave_idx];
    slave_idx = (slave_idx + 1 == (nine_mode ? 9 : 8)) ? 0 : slave_idx + 1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!auto_pop || !rst_done) mon_pop = 1'b0;
    else if (mon_pop) mon_pop = 1'b0;
    else if (rx_flag) begin
      if (exp_q.size() != 0) begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({rd_bit9, rd_data} == e, "R2", "received word",
              int'({rd_bit9, rd_data}), int'(e));
      end else if (!discard_ok) begin
        check(1'b0, "R4", "unexpected word", int'({rd_bit9, rd_data}), 0);
      end
      mon_pop = 1'b1;
    end
  end

  task automatic write_ctl(input bit s, input bit c, input bit n, input bit ie);
    @(negedge clk);
    ctl_we = 1'b1; ctl_single = s; ctl_cont = c; ctl_nine = n; ctl_ie = ie;
    nine_mode = n;
    @(negedge clk);
    ctl_we = 1'b0;
    if (!s && !c) slave_idx = 0;
  endtask

  task automatic send(input logic [8:0] w, input bit expect_it);
    send_q.push_back(w);
    if (expect_it) exp_q.push_back(w);
  endtask

  task automatic pop_once();
    @(negedge clk); man_pop = 1'b1;
    @(negedge clk); man_pop = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 5000 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, req, "expected words left", exp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_flag(input string req);
    for (int i = 0; i < 3000 && !rx_flag; i++) @(negedge clk);
    check(rx_flag == 1'b1, req, "rx_flag after word", rx_flag, 1);
  endtask

  task automatic stop_all();
    discard_ok = 1; auto_pop = 1;
    write_ctl(0, 0, nine_mode, 1);
    repeat (10) @(negedge clk);
    discard_ok = 0; auto_pop = 0;
    send_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r0;
    rst_n = 1'b0; ctl_we = 0; ctl_single = 0; ctl_cont = 0; ctl_nine = 0; ctl_ie = 0;
    baud_div = 8'd1; mon_pop = 0; man_pop = 0; sdata_i = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_done = 1;

    // reset state
    check(sclk_o == 0, "R1", "sclk at reset", sclk_o, 0);
    check(rx_flag == 0 && irq == 0, "R10", "flag/irq at reset", {rx_flag, irq}, 0);
    check(st_ovr == 0 && st_single == 0 && st_cont == 0, "R9", "status at reset",
          {st_ovr, st_single, st_cont}, 0);

    // R3 single word
    send(9'h0A5, 1);
    write_ctl(1, 0, 0, 1);
    wait_flag("R3");
    check(irq == 1, "R10", "irq with enable", irq, 1);
    check(st_single == 0, "R3", "single self-clear", st_single, 0);
    r0 = rise_cnt;
    repeat (60) @(negedge clk);
    check(rise_cnt == r0 && sclk_o == 0, "R3", "clock stopped after word", rise_cnt - r0, 0);
    auto_pop = 1;
    wait_drain("R2");
    check(rx_flag == 0 && irq == 0, "R10", "flag clears when empty", {rx_flag, irq}, 0);
    auto_pop = 0;

    // R4 continuous, R1 period at div=2
    baud_div = 8'd2;
    auto_pop = 1; discard_ok = 1;
    send(9'h03C, 1); send(9'h081, 1); send(9'h0FF, 1);
    write_ctl(0, 1, 0, 1);
    wait_drain("R4");
    check(int'((t_last - t_prev) / CLK_PERIOD) == 12, "R1", "period div=2",
          int'((t_last - t_prev) / CLK_PERIOD), 12);
    stop_all();
    r0 = rise_cnt;
    repeat (40) @(negedge clk);
    check(rise_cnt == r0 && st_cont == 0, "R4", "clear stops clock", rise_cnt - r0, 0);

    // R5 precedence, R1 period at div=0
    baud_div = 8'd0;
    auto_pop = 1; discard_ok = 1;
    send(9'h012, 1); send(9'h034, 1); send(9'h056, 1);
    write_ctl(1, 1, 0, 1);
    wait_drain("R5");
    check(st_cont == 1, "R5", "continuous still set", st_cont, 1);
    check(int'((t_last - t_prev) / CLK_PERIOD) == 4, "R1", "period div=0",
          int'((t_last - t_prev) / CLK_PERIOD), 4);
    stop_all();

    // R6 / R7 nine-bit entries held, irq gated off
    baud_div = 8'd1;
    send(9'h15A, 0);
    write_ctl(1, 0, 1, 0);
    wait_flag("R6");
    check(irq == 0, "R10", "irq gated by enable", irq, 0);
    send(9'h0C3, 0);
    write_ctl(1, 0, 1, 0);
    for (int i = 0; i < 3000 && st_single; i++) @(negedge clk);
    check(rx_flag == 1, "R7", "two words held", rx_flag, 1);
    check({rd_bit9, rd_data} == 9'h15A, "R6", "head entry", int'({rd_bit9, rd_data}), 'h15A);
    pop_once();
    check({rd_bit9, rd_data} == 9'h0C3, "R6", "second entry after pop",
          int'({rd_bit9, rd_data}), 'h0C3);
    pop_once();
    check(rx_flag == 0, "R7", "empty after two pops", rx_flag, 0);
    pop_once();
    check(rx_flag == 0, "R7", "pop on empty ignored", rx_flag, 0);
    auto_pop = 1;
    send(9'h177, 1);
    write_ctl(1, 0, 1, 1);
    wait_drain("R7");
    auto_pop = 0;

    // R8 / R9 overrun
    baud_div = 8'd0;
    send(9'h011, 1); send(9'h022, 1); send(9'h033, 0);
    write_ctl(0, 1, 0, 1);
    for (int i = 0; i < 3000 && !st_ovr; i++) @(negedge clk);
    check(st_ovr == 1, "R8", "overrun set", st_ovr, 1);
    check(rx_flag == 1, "R8", "fifo still full", rx_flag, 1);
    r0 = rise_cnt;
    repeat (40) @(negedge clk);
    check(rise_cnt == r0 && sclk_o == 0, "R8", "clock halted in overrun", rise_cnt - r0, 0);
    write_ctl(1, 1, 0, 1);
    repeat (5) @(negedge clk);
    check(st_ovr == 1, "R9", "write keeping cont leaves overrun", st_ovr, 1);
    write_ctl(0, 0, 0, 1);
    check(st_ovr == 0, "R9", "write clearing cont clears overrun", st_ovr, 0);
    auto_pop = 1;
    wait_drain("R8");
    repeat (5) @(negedge clk);
    check(rx_flag == 0, "R8", "third word discarded", rx_flag, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule